// File: doc/BRIEF.md
# Power-up repair chain load sequencer

This controller runs once after reset. It loads a segmented repair chain from a small bit store. The chain has a row of segment-select cells. Each cell decides whether its segment of repair registers sits in the scan path or is skipped.

The load runs in two passes:
- **Configuration pass.** With the select cells forming the path, the sequencer shifts in the segment-selection bits. It then commits them and clears the select cells' shift stages.
- **Data pass.** With the segments now forming the path, it shifts in the repair bits of only the selected segments.

Neither pass uses a hard-wired length. Each pass first flushes the path with zeros. It then injects a single 1 ahead of the payload and counts clocks until that 1 reaches the serial output. At that point the payload sits exactly in place and the count is the measured path length. The sequencer compares the measured length with the length it expects. A missing marker ends the run with a timeout status, and a wrong count ends it with a length status. The bit store is read combinationally: `rd_addr` out, `rd_bit` back in the same cycle.

Top module: `repair_chain_loader`

## Requirements
- R1: While reset is low, and for exactly one cycle after its release, `chain_rst` is 1, `cfg_mode` is 1, and `shift_en`, `sel_update`, `sel_clear`, `done` and `err` are 0. The sequence then starts without any further input.
- R2: Next, for LIMIT = NSEG*(SEG_LEN+1) cycles, `cfg_mode` is 1, `shift_en` is 1 and `chain_si` is 0.
- R3: Next, in configuration load cycle k, `shift_en` is 1 and `chain_si` is driven as follows:
  - k = 0: the marker bit, 1.
  - k = 1 to NSEG: the store bit at address k-1.
  - any later k: 0.
  Selection bit j ends in select cell j, counted from the serial-output end, and a 1 means that segment is in the path.
- R4: A load pass ends in the cycle where `chain_so` is 1. The cycle count k at that point is the measured length, and the shift in that cycle still takes place.
- R5: A configuration length equal to NSEG gives one cycle of `sel_update`, then one cycle of `sel_clear`, both with `cfg_mode` 1. The chain's select cells then hold the selection bits.
- R6: The data pass has `cfg_mode` 0 and the same LIMIT-cycle zero flush, then a marker followed by store bits from address NSEG+i. Selected segments fill in ascending order from the serial-output end, with bit 0 of each segment nearest the output. Segments that are not selected keep all-zero contents.
- R7: A measured data length equal to SEG_LEN times the number of selected segments raises `done` in the next cycle. `done` then stays 1, with no further shifting and with `err` 0.
- R8: If no marker returns by count LIMIT, the sequencer enters error state in the next cycle with `err_code` 2'b01. Error state is sticky and has every strobe at 0.
- R9: A measured length that differs from the expected one gives error state with `err_code` 2'b10.
- R10: With no segment selected, the data pass measures length 0 in its first load cycle and finishes with `done`.
- R11: At most one of `chain_rst`, `shift_en`, `sel_update` and `sel_clear` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chain_rst | output | 1 | Clears repair registers and all select cells |
| cfg_mode | output | 1 | 1: select cells form the path; 0: selected segments form the path |
| shift_en | output | 1 | Shift the active path by one bit |
| chain_si | output | 1 | Serial data into the path |
| chain_so | input | 1 | Serial data out of the path |
| sel_update | output | 1 | Commit the select cells' shift stages to their select stages |
| sel_clear | output | 1 | Clear the select cells' shift stages |
| rd_addr | output | ADDR_W | Bit-store address |
| rd_bit | input | 1 | Bit-store data for `rd_addr`, same cycle |
| done | output | 1 | Load finished correctly (sticky) |
| err | output | 1 | Load failed (sticky) |
| err_code | output | 2 | 01 timeout, 10 length mismatch, 00 none |

## Verification
Every output is decoded from the state and the step counter, so a result appears in the cycle after the edge that enters its phase.
- The marker is seen at `chain_so` in a cycle, and the next phase's outputs, including `done` or `err`, appear after the following edge.
- `chain_si` follows `rd_bit` within the same cycle.

The bench builds a queue of expected output vectors from the requirement timeline, one entry per cycle from reset release. It pops and compares one entry at each falling edge. It then reads the final contents of its behavioural chain model and checks them against the store.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [3:0] {
    S_RST, S_CFG_FLUSH, S_CFG_LOAD, S_CFG_UPD, S_CFG_CLR,
    S_DAT_FLUSH, S_DAT_LOAD, S_DONE, S_ERR
  } rcl_state_e;

  localparam logic [1:0] ERR_NONE    = 2'b00;
  localparam logic [1:0] ERR_TIMEOUT = 2'b01;
  localparam logic [1:0] ERR_LENGTH  = 2'b10;
endpackage

// File: rtl/rcl_step_ctr.sv
module rcl_step_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/rcl_sel_tally.sv
module rcl_sel_tally #(
  parameter int NSEG = 4,
  parameter int W    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)      q_d = '0;
    else if (inc) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R6: selected-segment count never exceeds the number of segments
  p_tally_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q <= W'(NSEG));
endmodule

// File: rtl/rcl_seq_fsm.sv
module rcl_seq_fsm
  import rcl_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int SEG_LEN = 8,
  parameter int LIMIT   = 36,
  parameter int CNT_W   = 6,
  parameter int ADDR_W  = 6,
  parameter int TAL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_so,
  input  logic              rd_bit,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [TAL_W-1:0]  tally,
  output logic              cnt_clr,
  output logic              cnt_en,
  output logic              tally_clr,
  output logic              tally_inc,
  output logic              chain_rst,
  output logic              cfg_mode,
  output logic              shift_en,
  output logic              chain_si,
  output logic              sel_update,
  output logic              sel_clear,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  rcl_state_e        state_q, state_d;
  logic [1:0]        code_q, code_d;
  logic              code_en;
  logic [CNT_W-1:0]  idx, exp_len;
  logic              cfg_in, dat_in, last_flush, at_limit;

  assign idx        = cnt - CNT_W'(1);
  assign exp_len    = CNT_W'(tally) * CNT_W'(SEG_LEN);
  assign cfg_in     = (cnt != '0) && (cnt <= CNT_W'(NSEG));
  assign dat_in     = (cnt != '0) && (cnt <= exp_len);
  assign last_flush = (cnt == CNT_W'(LIMIT - 1));
  assign at_limit   = (cnt == CNT_W'(LIMIT));

  always_comb begin
    state_d = state_q;
    code_d  = ERR_NONE;
    unique case (state_q)
      S_RST:       state_d = S_CFG_FLUSH;
      S_CFG_FLUSH: if (last_flush) state_d = S_CFG_LOAD;
      S_CFG_LOAD: begin
        if (chain_so) begin
          if (cnt == CNT_W'(NSEG)) state_d = S_CFG_UPD;
          else begin state_d = S_ERR; code_d = ERR_LENGTH; end
        end else if (at_limit) begin
          state_d = S_ERR; code_d = ERR_TIMEOUT;
        end
      end
      S_CFG_UPD:   state_d = S_CFG_CLR;
      S_CFG_CLR:   state_d = S_DAT_FLUSH;
      S_DAT_FLUSH: if (last_flush) state_d = S_DAT_LOAD;
      S_DAT_LOAD: begin
        if (chain_so) begin
          if (cnt == exp_len) state_d = S_DONE;
          else begin state_d = S_ERR; code_d = ERR_LENGTH; end
        end else if (at_limit) begin
          state_d = S_ERR; code_d = ERR_TIMEOUT;
        end
      end
      S_DONE:      state_d = S_DONE;
      S_ERR:       state_d = S_ERR;
      default:     state_d = S_RST;
    endcase
  end

  assign code_en   = (state_d == S_ERR) && (state_q != S_ERR);
  assign cnt_clr   = (state_d != state_q);
  assign cnt_en    = (state_q == S_CFG_FLUSH) || (state_q == S_CFG_LOAD) ||
                     (state_q == S_DAT_FLUSH) || (state_q == S_DAT_LOAD);
  assign tally_clr = (state_q == S_RST);
  assign tally_inc = (state_q == S_CFG_LOAD) && cfg_in && rd_bit;

  always_comb begin
    chain_si = 1'b0;
    rd_addr  = '0;
    if (state_q == S_CFG_LOAD) begin
      rd_addr  = ADDR_W'(idx);
      chain_si = (cnt == '0) ? 1'b1 : (cfg_in & rd_bit);
    end else if (state_q == S_DAT_LOAD) begin
      rd_addr  = ADDR_W'(idx) + ADDR_W'(NSEG);
      chain_si = (cnt == '0) ? 1'b1 : (dat_in & rd_bit);
    end
  end

  assign chain_rst  = (state_q == S_RST);
  assign cfg_mode   = (state_q == S_RST) || (state_q == S_CFG_FLUSH) ||
                      (state_q == S_CFG_LOAD) || (state_q == S_CFG_UPD) ||
                      (state_q == S_CFG_CLR);
  assign shift_en   = cnt_en;
  assign sel_update = (state_q == S_CFG_UPD);
  assign sel_clear  = (state_q == S_CFG_CLR);
  assign done       = (state_q == S_DONE);
  assign err        = (state_q == S_ERR);
  assign err_code   = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_RST;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= ERR_NONE;
    else if (code_en) code_q <= code_d;
  end

  // R11: the chain strobes never overlap
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chain_rst, shift_en, sel_update, sel_clear}));
  // R5: a commit is always followed by a clear of the shift stages
  p_upd_then_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_update |=> (sel_clear && cfg_mode));
  // R7: done is sticky, exclusive of err, and stops shifting
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !err && !shift_en));
  // R8: error state is sticky with a stable code
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(err_code) && !shift_en));
  // R8: the step count never passes the timeout limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LIMIT));
  // R9: a nonzero code only accompanies error state
  p_code_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ERR_NONE) |-> err);
endmodule

// File: rtl/repair_chain_loader.sv
module repair_chain_loader #(
  parameter int NSEG    = 4,
  parameter int SEG_LEN = 8,
  localparam int LIMIT  = NSEG * (SEG_LEN + 1),
  localparam int CNT_W  = $clog2(LIMIT + 1),
  localparam int ADDR_W = $clog2(NSEG * (SEG_LEN + 1)),
  localparam int TAL_W  = $clog2(NSEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              chain_rst,
  output logic              cfg_mode,
  output logic              shift_en,
  output logic              chain_si,
  input  logic              chain_so,
  output logic              sel_update,
  output logic              sel_clear,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_bit,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  logic [CNT_W-1:0] cnt;
  logic [TAL_W-1:0] tally;
  logic             cnt_clr, cnt_en, tally_clr, tally_inc;

  rcl_step_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .q(cnt)
  );

  rcl_sel_tally #(.NSEG(NSEG), .W(TAL_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(tally_clr), .inc(tally_inc), .q(tally)
  );

  rcl_seq_fsm #(
    .NSEG(NSEG), .SEG_LEN(SEG_LEN), .LIMIT(LIMIT),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TAL_W(TAL_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .chain_so(chain_so), .rd_bit(rd_bit),
    .cnt(cnt), .tally(tally), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .tally_clr(tally_clr), .tally_inc(tally_inc), .chain_rst(chain_rst),
    .cfg_mode(cfg_mode), .shift_en(shift_en), .chain_si(chain_si),
    .sel_update(sel_update), .sel_clear(sel_clear), .rd_addr(rd_addr),
    .done(done), .err(err), .err_code(err_code)
  );
endmodule

// File: tb/repair_chain_loader_tb_top.sv
module repair_chain_loader_tb_top;
  localparam int NSEG    = 4;
  localparam int SEG_LEN = 8;
  localparam int LIMIT   = NSEG * (SEG_LEN + 1);
  localparam int NBITS   = NSEG * SEG_LEN;
  localparam int DEPTH   = NSEG * (SEG_LEN + 1);
  localparam int ADDR_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_rst, cfg_mode, shift_en, chain_si, chain_so;
  logic sel_update, sel_clear, rd_bit, done, err;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0] err_code;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  repair_chain_loader #(.NSEG(NSEG), .SEG_LEN(SEG_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .chain_rst(chain_rst), .cfg_mode(cfg_mode),
    .shift_en(shift_en), .chain_si(chain_si), .chain_so(chain_so),
    .sel_update(sel_update), .sel_clear(sel_clear), .rd_addr(rd_addr),
    .rd_bit(rd_bit), .done(done), .err(err), .err_code(err_code)
  );

  // bit store
  logic mem [0:DEPTH-1];
  assign rd_bit = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 1'b0;

  // behavioural segmented chain: index 0 is nearest the serial output
  logic [NSEG:0]    cfg_cells;
  logic [NSEG-1:0]  sel_r;
  logic [NBITS-1:0] dat;
  logic brk = 1'b0, extra = 1'b0;
  logic [NSEG:0]    t_cfg;
  logic [NBITS-1:0] t_dat;
  logic carry, tmp;

  always_comb begin
    chain_so = 1'b0;
    if (cfg_mode) chain_so = cfg_cells[0];
    else if (!brk) begin
      chain_so = chain_si;
      for (int s = NSEG - 1; s >= 0; s--)
        if (sel_r[s]) chain_so = dat[s*SEG_LEN];
    end
  end

  always @(posedge clk) begin
    if (chain_rst) begin
      cfg_cells <= '0; sel_r <= '0; dat <= '0;
    end else begin
      if (sel_clear) cfg_cells <= '0;
      if (sel_update) sel_r <= cfg_cells[NSEG-1:0];
      if (shift_en && cfg_mode) begin
        t_cfg = cfg_cells >> 1;
        if (extra) t_cfg[NSEG] = chain_si;
        else begin t_cfg[NSEG-1] = chain_si; t_cfg[NSEG] = 1'b0; end
        cfg_cells <= t_cfg;
      end
      if (shift_en && !cfg_mode) begin
        t_dat = dat;
        carry = chain_si;
        for (int s = NSEG - 1; s >= 0; s--)
          if (sel_r[s])
            for (int b = SEG_LEN - 1; b >= 0; b--) begin
              tmp = t_dat[s*SEG_LEN+b];
              t_dat[s*SEG_LEN+b] = carry;
              carry = tmp;
            end
        dat <= t_dat;
      end
    end
  end

  // expected per-cycle output vectors: {rst,cfg,shift,si,upd,clr,done,err,code}
  logic [9:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [9:0] mk(logic r, logic c, logic sh, logic si,
                                    logic u, logic cl, logic d, logic e,
                                    logic [1:0] code);
    return {r, c, sh, si, u, cl, d, e, code};
  endfunction

  task automatic push(logic [9:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic build_exp(logic [NSEG-1:0] sel);
    int lc, nsel, elen;
    logic si;
    push(mk(1,1,0,0,0,0,0,0,2'b00), "R1");
    for (int k = 0; k < LIMIT; k++) push(mk(0,1,1,0,0,0,0,0,2'b00), "R2");
    lc = extra ? NSEG + 1 : NSEG;
    for (int k = 0; k <= lc; k++) begin
      si = (k == 0) ? 1'b1 : ((k - 1 < NSEG) ? sel[k-1] : 1'b0);
      push(mk(0,1,1,si,0,0,0,0,2'b00), (k == lc) ? "R4" : "R3");
    end
    if (extra) begin
      for (int k = 0; k < 5; k++) push(mk(0,0,0,0,0,0,0,1,2'b10), "R9");
      return;
    end
    push(mk(0,1,0,0,1,0,0,0,2'b00), "R5");
    push(mk(0,1,0,0,0,1,0,0,2'b00), "R5");
    for (int k = 0; k < LIMIT; k++) push(mk(0,0,1,0,0,0,0,0,2'b00), "R6");
    nsel = $countones(sel);
    elen = nsel * SEG_LEN;
    if (brk) begin
      for (int k = 0; k <= LIMIT; k++) begin
        si = (k == 0) ? 1'b1 : ((k - 1 < elen) ? mem[NSEG+k-1] : 1'b0);
        push(mk(0,0,1,si,0,0,0,0,2'b00), "R8");
      end
      for (int k = 0; k < 5; k++) push(mk(0,0,0,0,0,0,0,1,2'b01), "R8");
      return;
    end
    for (int k = 0; k <= elen; k++) begin
      si = (k == 0) ? 1'b1 : mem[NSEG+k-1];
      push(mk(0,0,1,si,0,0,0,0,2'b00), (nsel == 0) ? "R10" : "R6");
    end
    for (int k = 0; k < 5; k++) push(mk(0,0,0,0,0,0,1,0,2'b00), "R7");
  endtask

  task automatic check_cycle(int step);
    logic [9:0] got, ex;
    string tg;
    got = {chain_rst, cfg_mode, shift_en, chain_si, sel_update, sel_clear,
           done, err, err_code};
    ex = exp_q.pop_front();
    tg = tag_q.pop_front();
    checks++;
    if (got !== ex) begin
      errors++;
      $display("FAIL %s step %0d: got %b expected %b", tg, step, got, ex);
    end
    checks++;
    if (!$onehot0({chain_rst, shift_en, sel_update, sel_clear})) begin
      errors++;
      $display("FAIL R11 step %0d: strobes %b expected at most one set", step,
               {chain_rst, shift_en, sel_update, sel_clear});
    end
  endtask

  task automatic run(logic [NSEG-1:0] sel, logic b, logic x, int seed);
    int step, r;
    logic e;
    for (int j = 0; j < NSEG; j++) mem[j] = sel[j];
    for (int j = 0; j < NBITS; j++)
      mem[NSEG+j] = logic'(((j * 5 + seed) % 3) == 0) ^ logic'(j % 2);
    brk = b;
    extra = x;
    exp_q.delete();
    tag_q.delete();
    build_exp(sel);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (!(chain_rst === 1'b1 && done === 1'b0 && err === 1'b0 && shift_en === 1'b0)) begin
      errors++;
      $display("FAIL R1 in reset: got rst=%b done=%b err=%b sh=%b expected 1 0 0 0",
               chain_rst, done, err, shift_en);
    end
    rst_n = 1'b1;
    #1;
    step = 0;
    while (exp_q.size() > 0) begin
      check_cycle(step);
      step++;
      @(negedge clk);
      #1;
    end
    if (!x) begin
      checks++;
      if (sel_r !== sel) begin
        errors++;
        $display("FAIL R5 select cells: got %b expected %b", sel_r, sel);
      end
    end
    if (!x && !b) begin
      r = 0;
      for (int s = 0; s < NSEG; s++) begin
        for (int k = 0; k < SEG_LEN; k++) begin
          e = sel[s] ? mem[NSEG + r*SEG_LEN + k] : 1'b0;
          checks++;
          if (dat[s*SEG_LEN+k] !== e) begin
            errors++;
            $display("FAIL R6 segment %0d bit %0d: got %b expected %b",
                     s, k, dat[s*SEG_LEN+k], e);
          end
        end
        if (sel[s]) r++;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: got no finish, expected finish before %0d cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(4'b0101, 1'b0, 1'b0, 1);  // R6 alternating selection
    run(4'b0000, 1'b0, 1'b0, 2);  // R10 nothing selected
    run(4'b1111, 1'b0, 1'b0, 3);  // R7 full chain
    run(4'b1000, 1'b0, 1'b0, 4);  // R6 only the segment farthest from output
    run(4'b1001, 1'b1, 1'b0, 5);  // R8 broken data path
    run(4'b0110, 1'b0, 1'b1, 6);  // R9 extra configuration cell
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule